// File: doc/BRIEF.md
# Serial Command Port for a Wiper Register Bank

This block is the serial slave side of a small bank of wiper position registers. A host selects the block with an active-low chip select and clocks commands in on a serial data line. The block answers on a serial output whose driver is enabled only while the block is selected. Every frame begins with a 4-bit register address and a 2-bit command code. A write or read frame has 16 bits and ends with a 9-bit value. An increment or decrement frame is one byte long. Several frames may follow one another under one chip select.

The serial pins are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the clock edges are found in the system clock domain. The serial clock must therefore stay at each level for several system clock periods. The block accepts either serial clock idle level. Input bits are captured on rising serial clock edges, and the output changes only on falling edges. After the address and command bits have arrived, the output reports whether the command is legal. An illegal command locks the port until the end of the select. The register contents drive the wiper outputs in parallel.

Top module: `spi_wiper_if`

## Requirements
- R1: After reset, every register holds FS/2 (128 by default), and `sdo_oe` is low.
- R2: A frame is sent MSB first. Bits 15..12 are the address and bits 11..10 are the command: 00 write, 01 increment, 10 decrement, 11 read. Bit 9 is ignored and bits 8..0 carry the data. A write updates the register only on the 16th rising edge.
- R3: A write value above FS (256 by default) is stored as FS.
- R4: In a read frame, the output sampled at rising edges 8 to 16 carries the register value from bit 8 down to bit 0.
- R5: The output sampled at rising edges 1 to 6 is 1. At edge 7 it is 1 for a legal command and 0 for an illegal one. It is 1 for the rest of write, increment and decrement frames.
- R6: Increment and decrement frames are 8 bits long (address, command, two ignored bits). They step the register by one and stop at FS and at 0.
- R7: An address of NREG or above is illegal for every command. The output then stays 0 until chip select rises, further clocks are ignored, and no register changes.
- R8: While chip select is high, `sdo_oe` is low, and a partial frame is discarded without effect. While chip select is low, `sdo_oe` is high.
- R9: Operation is identical with the serial clock idling low and idling high. A falling edge before the first rising edge has no effect.
- R10: Frames sent back to back under one chip select are each decoded from their own start.
- R11: `sdo` changes only after a falling serial clock edge, or when the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sck | input | 1 | Serial clock (asynchronous) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (high-impedance when low) |
| wiper | output | NREG*9 | Register contents; register i in bits [9i+8:9i] |

## Verification
The assertions check on every cycle that no register ever exceeds full scale and that the bank stays frozen while an error is latched. They also check that a latched error pins the bit counter at the command position, that deselection clears the counter and the error, and that the output moves only on falling edges. The bench scenarios are needed to show that frames decode correctly in both clock idle levels. They also show read data arriving in the right bit slots, writes clamping, increments and decrements saturating, partial frames being dropped, and back-to-back frames under one select.

// File: rtl/spi_wiper_if.sv
module spi_wiper_if #(
  parameter int NREG = 4,
  parameter int FS   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [NREG*9-1:0] wiper
);
  localparam int DW = 9;
  localparam int IW = $clog2(NREG);
  localparam logic [DW-1:0] FSV = DW'(FS);
  localparam logic [DW-1:0] MID = DW'(FS / 2);
  localparam logic [1:0] C_WR = 2'b00, C_INC = 2'b01, C_DEC = 2'b10, C_RD = 2'b11;

  logic [2:0] cs_q, sck_q;
  logic [1:0] sdi_q;
  logic [DW-1:0] regs [NREG];
  logic [4:0] cnt;
  logic [14:0] sh;
  logic err;
  logic [3:0] op_a;
  logic [1:0] op_c;
  logic [DW-1:0] rd_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= 3'b111;
      sck_q <= '0;
      sdi_q <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      sdi_q <= {sdi_q[0], sdi};
    end

  wire cs_s  = cs_q[1];
  wire rise  = !cs_s && sck_q[1] && !sck_q[2];
  wire fall  = !cs_s && !sck_q[1] && sck_q[2];
  wire [15:0] nxt = {sh, sdi_q[1]};
  wire addr_ok = int'(nxt[5:2]) < NREG;
  wire [IW-1:0] ix = op_a[IW-1:0];
  wire [DW-1:0] wr_val = (nxt[DW-1:0] > FSV) ? FSV : nxt[DW-1:0];

  assign sdo_oe = !cs_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= MID;
      cnt <= '0; sh <= '0; err <= 1'b0; op_a <= '0; op_c <= '0;
      rd_sh <= '0; sdo <= 1'b1;
    end else if (cs_s) begin
      cnt <= '0;
      err <= 1'b0;
      sdo <= 1'b1;
    end else if (rise && !err) begin
      sh  <= nxt[14:0];
      cnt <= cnt + 5'd1;
      if (cnt == 5'd5) begin
        op_a <= nxt[5:2];
        op_c <= nxt[1:0];
        if (!addr_ok) err <= 1'b1;
        else if (nxt[1:0] == C_RD) rd_sh <= regs[nxt[IW+1:2]];
      end
      if (cnt == 5'd7 && (op_c == C_INC || op_c == C_DEC)) begin
        cnt <= '0;
        if (op_c == C_INC && regs[ix] < FSV) regs[ix] <= regs[ix] + 1'b1;
        if (op_c == C_DEC && regs[ix] != '0) regs[ix] <= regs[ix] - 1'b1;
      end
      if (cnt == 5'd15) begin
        cnt <= '0;
        if (op_c == C_WR) regs[ix] <= wr_val;
      end
    end else if (fall) begin
      if (cnt == 5'd6) sdo <= !err;
      else if (op_c == C_RD && cnt >= 5'd7) begin
        sdo   <= rd_sh[DW-1];
        rd_sh <= rd_sh << 1;
      end else sdo <= 1'b1;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign wiper[g*DW +: DW] = regs[g];
    a_r6_fs_bound: assert property (@(posedge clk) disable iff (!rst_n) regs[g] <= FSV);
  end

  a_r7_err_freeze: assert property (@(posedge clk) disable iff (!rst_n) err |=> $stable(wiper));
  a_r7_err_count:  assert property (@(posedge clk) disable iff (!rst_n) err |-> cnt == 5'd6);
  a_r8_deselect:   assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> (cnt == 5'd0 && !err));
  a_r2_cnt_range:  assert property (@(posedge clk) disable iff (!rst_n) cnt <= 5'd15);
  a_r11_sdo_edge:  assert property (@(posedge clk) disable iff (!rst_n) (!cs_s && !fall) |=> $stable(sdo));
endmodule

// File: tb/sim_spi_wiper_if.sv
module sim_spi_wiper_if;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [35:0] wiper;
  int checks = 0, errors = 0;
  int exp_v [4];

  spi_wiper_if #(.NREG(4), .FS(256)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .wiper(wiper));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [31:0] d, input bit m11, output logic [31:0] got);
    got = '0;
    sck = m11;
    #160;
    cs_n = 1'b0;
    #80;
    chk(sdo_oe === 1'b1, "R8 oe while selected", sdo_oe, 1);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0;
      sdi = d[n-1-i];
      #80;
      got[n-1-i] = sdo;
      sck = 1'b1;
      #80;
    end
    if (!m11) sck = 1'b0;
    #80;
    cs_n = 1'b1;
    #160;
  endtask

  task automatic check_bank(input string tag);
    for (int a = 0; a < 4; a++)
      chk(wiper[a*9 +: 9] == 9'(exp_v[a]), tag, wiper[a*9 +: 9], exp_v[a]);
  endtask

  function automatic int clampv(input int v);
    return (v > 256) ? 256 : v;
  endfunction

  logic [31:0] got;
  int vals [8] = '{0, 1, 85, 170, 255, 256, 257, 511};

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #33 rst_n = 1'b1;
    #50;
    for (int a = 0; a < 4; a++) exp_v[a] = 128;
    check_bank("R1 reset value");
    chk(sdo_oe == 1'b0, "R1 oe after reset", sdo_oe, 0);

    for (int a = 0; a < 4; a++)
      for (int k = 0; k < 8; k++) begin
        xfer(16, {16'h0, 4'(a), 2'b00, 1'b0, 9'(vals[k])}, bit'((a + k) % 2), got);
        chk(got[15:0] == 16'hFFFF, "R5 write frame output", got[15:0], 16'hFFFF);
        exp_v[a] = clampv(vals[k]);
        chk(wiper[a*9 +: 9] == 9'(exp_v[a]), "R2 R3 write value", wiper[a*9 +: 9], exp_v[a]);
        xfer(16, {16'h0, 4'(a), 2'b11, 10'h0}, bit'((a + k + 1) % 2), got);
        chk(got[15:0] == {7'h7F, 9'(exp_v[a])}, "R4 R9 R11 read data", got[15:0], {7'h7F, 9'(exp_v[a])});
      end
    check_bank("R2 bank after sweep");
    chk(sdo_oe == 1'b0, "R8 oe deselected", sdo_oe, 0);

    xfer(16, {16'h0, 4'd2, 2'b00, 1'b1, 9'd5}, 1'b0, got);
    exp_v[2] = 5;
    chk(wiper[18 +: 9] == 9'd5, "R2 bit9 ignored", wiper[18 +: 9], 5);

    xfer(16, {16'h0, 4'd1, 2'b00, 10'd254}, 1'b1, got);
    exp_v[1] = 254;
    for (int k = 0; k < 4; k++) begin
      xfer(8, {24'h0, 4'd1, 2'b01, 2'b11}, bit'(k % 2), got);
      chk(got[7:0] == 8'hFF, "R5 increment output", got[7:0], 8'hFF);
      exp_v[1] = clampv(exp_v[1] + 1);
      chk(wiper[9 +: 9] == 9'(exp_v[1]), "R6 increment saturate", wiper[9 +: 9], exp_v[1]);
    end
    xfer(16, {16'h0, 4'd3, 2'b00, 10'd2}, 1'b0, got);
    exp_v[3] = 2;
    for (int k = 0; k < 4; k++) begin
      xfer(8, {24'h0, 4'd3, 2'b10, 2'b00}, bit'(k % 2), got);
      exp_v[3] = (exp_v[3] > 0) ? exp_v[3] - 1 : 0;
      chk(wiper[27 +: 9] == 9'(exp_v[3]), "R6 decrement saturate", wiper[27 +: 9], exp_v[3]);
    end

    xfer(32, {4'd0, 2'b00, 10'd100, 4'd0, 2'b11, 10'd0}, 1'b1, got);
    exp_v[0] = 100;
    chk(got[15:0] == {7'h7F, 9'd100}, "R10 write then read in one select", got[15:0], {7'h7F, 9'd100});
    xfer(16, {16'h0, 4'd0, 2'b01, 2'b00, 4'd0, 2'b01, 2'b00}, 1'b0, got);
    exp_v[0] = 102;
    chk(wiper[0 +: 9] == 9'd102, "R10 two increments in one select", wiper[0 +: 9], 102);

    for (int a = 4; a < 16; a++)
      for (int c = 0; c < 4; c++) begin
        xfer(16, {16'h0, 4'(a), 2'(c), 10'h0AA}, bit'(c % 2), got);
        chk(got[15:0] == 16'hFC00, "R5 R7 error output", got[15:0], 16'hFC00);
      end
    check_bank("R7 bank unchanged after errors");
    xfer(32, {4'd9, 2'b00, 10'd7, 4'd1, 2'b00, 10'd7}, 1'b0, got);
    chk(got[31:0] == 32'hFC00_0000, "R7 output held low", got, 32'hFC00_0000);
    check_bank("R7 later frame ignored");

    xfer(10, {22'h0, 4'd2, 2'b00, 4'hF}, 1'b1, got);
    check_bank("R8 ten bit frame discarded");
    xfer(15, {17'h0, 4'd2, 2'b00, 9'h1F}, 1'b0, got);
    check_bank("R8 fifteen bit frame discarded");
    xfer(16, {16'h0, 4'd2, 2'b00, 10'd77}, 1'b1, got);
    exp_v[2] = 77;
    check_bank("R8 R9 frame after abort");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule